// File: doc/BRIEF.md
# Zero-Operand Stack Execution Core

This block is a compact execution core for a stack machine whose arithmetic instructions name no operands. It fetches 16-bit instructions from a synchronous program memory and keeps its working values in a small evaluation stack held in internal registers. Memory operands reach that stack through a word-addressed data memory. Their address is formed from a frame base plus a signed byte displacement carried in the instruction.

Software places operands in a frame in data memory and sets `sp_base` to the frame's word address. It writes a program at instruction address 0 and pulses `start`. The core runs until it meets a halt instruction, which raises `done`, or until it detects a stack or encoding fault, which raises `err`. Both memories have a read latency of one clock.

Top module: `zstack_core`

## Requirements
- R1: A one-cycle pulse on `start` is accepted while the core is idle, halted or faulted. It empties the stack, resets the program counter to instruction address 0, captures `sp_base`, and clears `done` and `err`. An instruction word holds the opcode in bits [15:8] and a signed byte displacement in bits [7:0]. The opcodes are 0x00 halt, 0x01 push, 0x02 store, 0x03 pop, 0x10 add, 0x11 subtract and 0x12 multiply.
- R2: Push reads the data word at `sp_base` + displacement/4, where the displacement is sign-extended, so negative offsets reach below the base. The word read becomes the new top of stack.
- R3: Store writes the top of stack to the data word at `sp_base` + displacement/4. It leaves the stack unchanged.
- R4: Pop discards the top entry, so the entry below it becomes the top.
- R5: Add replaces the top two entries with their sum. Multiply replaces them with the low 32 bits of their product.
- R6: Subtract replaces the top two entries with (entry below top) minus (top), using 32-bit wrap-around.
- R7: The core faults in two cases: a push when the stack already holds 8 entries, or any instruction that finds fewer entries than it consumes (store and pop consume 1, arithmetic consumes 2). On a fault, `err` rises, the faulting instruction writes nothing, and fetching stops. `err` stays high until the next accepted start.
- R8: The core also faults, in the same way as R7, on a push or store whose displacement is not a multiple of 4 (bits [1:0] not zero), and on any opcode not listed in R1.
- R9: A halt instruction raises `done` and stops fetching. `done` stays high until the next accepted start.
- R10: `done` and `err` are never high together, and the data memory never sees a read and a write in the same cycle.
- R11: After reset, `done`, `err`, `imem_en`, `dmem_re` and `dmem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at instruction address 0 |
| sp_base | input | 8 | Frame base word address, captured at start |
| imem_en | output | 1 | Program memory read enable |
| imem_addr | output | 8 | Program memory word address |
| imem_rdata | input | 16 | Instruction word, valid one cycle after `imem_en` |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 8 | Data memory word address |
| dmem_wdata | output | 32 | Data memory write data |
| dmem_rdata | input | 32 | Data memory read data, valid one cycle after `dmem_re` |
| done | output | 1 | Halt instruction reached |
| err | output | 1 | Sticky fault flag |

## Verification
Fault detection and the memory side effect of the same instruction are decided in a single decode cycle. A store executed on an empty stack, a push onto a full stack and a misaligned store each ask for a memory access while also breaking a rule. Each of these is provoked by a short program that ends in a store aimed at a sentinel word. The test is judged by `err` being high, `done` being low and the sentinel word being unchanged.

// File: rtl/zstack_pkg.sv
package zstack_pkg;

    localparam int INSTR_W = 16;
    localparam int DISP_W  = 8;

    typedef enum logic [7:0] {
        OP_HALT  = 8'h00,
        OP_PUSH  = 8'h01,
        OP_STORE = 8'h02,
        OP_POP   = 8'h03,
        OP_ADD   = 8'h10,
        OP_SUB   = 8'h11,
        OP_MUL   = 8'h12
    } op_e;

    typedef struct packed {
        logic [7:0]        op;
        logic [DISP_W-1:0] disp;
    } instr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_LOAD,
        ST_HALT,
        ST_FAULT
    } state_e;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_HALT, OP_PUSH, OP_STORE, OP_POP,
            OP_ADD, OP_SUB, OP_MUL: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_alu(input logic [7:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

    function automatic logic op_is_mem(input logic [7:0] op);
        return (op == OP_PUSH) || (op == OP_STORE);
    endfunction

    // number of stack entries an instruction consumes
    function automatic logic [1:0] operands_needed(input logic [7:0] op);
        if (op_is_alu(op))                    return 2'd2;
        if (op == OP_STORE || op == OP_POP)   return 2'd1;
        return 2'd0;
    endfunction

    // signed word offset from a byte displacement
    function automatic logic signed [DISP_W-3:0] disp_words(input logic [DISP_W-1:0] d);
        return $signed(d[DISP_W-1:2]);
    endfunction

endpackage

// File: rtl/zstack_alu.sv
module zstack_alu
    import zstack_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [7:0]    op,
    input  logic [DW-1:0] below,
    input  logic [DW-1:0] top,
    output logic [DW-1:0] result
);
    always_comb begin
        case (op)
            OP_ADD:  result = below + top;
            OP_SUB:  result = below - top;
            OP_MUL:  result = below * top;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/zstack_lifo.sv
module zstack_lifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    input  logic                         fold,
    input  logic [DW-1:0]                fold_data,
    output logic [DW-1:0]                top,
    output logic [DW-1:0]                below,
    output logic [$clog2(DEPTH+1)-1:0]   depth,
    output logic                         full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] slot_q [DEPTH];
    logic [CW-1:0] depth_q;

    // one write enable per slot: push fills slot[depth], fold rewrites slot[depth-2]
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic wr_push, wr_fold;
        assign wr_push = push && (depth_q == CW'(i));
        assign wr_fold = fold && (depth_q == CW'(i + 2));
        always_ff @(posedge clk) begin
            if (rst)          slot_q[i] <= '0;
            else if (wr_push) slot_q[i] <= push_data;
            else if (wr_fold) slot_q[i] <= fold_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)       depth_q <= '0;
        else if (push)        depth_q <= depth_q + CW'(1);
        else if (pop || fold) depth_q <= depth_q - CW'(1);
    end

    always_comb begin
        top   = '0;
        below = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == CW'(i + 1)) top   = slot_q[i];
            if (depth_q == CW'(i + 2)) below = slot_q[i];
        end
    end

    assign depth = depth_q;
    assign full  = (depth_q == CW'(DEPTH));
endmodule

// File: rtl/zstack_core.sv
module zstack_core
    import zstack_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int IAW   = 8,
    parameter int DAW   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DAW-1:0]     sp_base,
    output logic               imem_en,
    output logic [IAW-1:0]     imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               dmem_re,
    output logic               dmem_we,
    output logic [DAW-1:0]     dmem_addr,
    output logic [DW-1:0]      dmem_wdata,
    input  logic [DW-1:0]      dmem_rdata,
    output logic               done,
    output logic               err
);
    localparam int CW = $clog2(DEPTH + 1);

    state_e         state_q, state_d;
    logic [IAW-1:0] pc_q;
    logic [DAW-1:0] base_q;

    instr_t         ins;
    logic           in_exec, launch, fault;
    logic           lf_push, lf_pop, lf_fold, lf_full;
    logic [DW-1:0]  lf_top, lf_below, alu_y;
    logic [CW-1:0]  lf_depth;

    assign ins     = instr_t'(imem_rdata);
    assign in_exec = (state_q == ST_EXEC);
    assign launch  = start && (state_q == ST_IDLE || state_q == ST_HALT || state_q == ST_FAULT);

    // every rule an instruction can break, decided in its execute cycle
    always_comb begin
        fault = 1'b0;
        if (in_exec) begin
            if (!op_known(ins.op))                                   fault = 1'b1;
            if (lf_depth < CW'(operands_needed(ins.op)))              fault = 1'b1;
            if (ins.op == OP_PUSH && lf_full)                        fault = 1'b1;
            if (op_is_mem(ins.op) && ins.disp[1:0] != 2'b00)         fault = 1'b1;
        end
    end

    assign lf_push = (state_q == ST_LOAD);
    assign lf_pop  = in_exec && !fault && (ins.op == OP_POP);
    assign lf_fold = in_exec && !fault && op_is_alu(ins.op);

    assign imem_en    = (state_q == ST_FETCH);
    assign imem_addr  = pc_q;
    assign dmem_re    = in_exec && !fault && (ins.op == OP_PUSH);
    assign dmem_we    = in_exec && !fault && (ins.op == OP_STORE);
    assign dmem_addr  = base_q + DAW'(disp_words(ins.disp));
    assign dmem_wdata = lf_top;
    assign done       = (state_q == ST_HALT);
    assign err        = (state_q == ST_FAULT);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_HALT, ST_FAULT: if (start) state_d = ST_FETCH;
            ST_FETCH:                   state_d = ST_EXEC;
            ST_EXEC: begin
                if (fault)                   state_d = ST_FAULT;
                else if (ins.op == OP_HALT)  state_d = ST_HALT;
                else if (ins.op == OP_PUSH)  state_d = ST_LOAD;
                else                         state_d = ST_FETCH;
            end
            ST_LOAD:                    state_d = ST_FETCH;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                pc_q   <= '0;
                base_q <= sp_base;
            end else if (in_exec) begin
                pc_q <= pc_q + IAW'(1);
            end
        end
    end

    zstack_lifo #(.DW(DW), .DEPTH(DEPTH)) u_lifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (launch),
        .push      (lf_push),
        .push_data (dmem_rdata),
        .pop       (lf_pop),
        .fold      (lf_fold),
        .fold_data (alu_y),
        .top       (lf_top),
        .below     (lf_below),
        .depth     (lf_depth),
        .full      (lf_full)
    );

    zstack_alu #(.DW(DW)) u_alu (
        .op     (ins.op),
        .below  (lf_below),
        .top    (lf_top),
        .result (alu_y)
    );
endmodule

// File: rtl/zstack_core_chk.sv
module zstack_core_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic imem_en,
    input logic dmem_re,
    input logic dmem_we,
    input logic done,
    input logic err
);
    // R10
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    // R10
    a_r10_no_read_write: assert property (@(posedge clk) disable iff (rst)
        !(dmem_re && dmem_we));
    // R7
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);
    // R7
    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!imem_en && !dmem_we && !dmem_re));
    // R9
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R9
    a_r9_halt_no_fetch: assert property (@(posedge clk) disable iff (rst)
        done |-> !imem_en);
    // R1
    a_r1_start_fetches: assert property (@(posedge clk) disable iff (rst)
        ((done || err) && start) |=> (imem_en && !done && !err));
endmodule

bind zstack_core zstack_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .imem_en (imem_en),
    .dmem_re (dmem_re),
    .dmem_we (dmem_we),
    .done    (done),
    .err     (err)
);

// File: tb/zstack_core_tb_top.sv
module zstack_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  sp_base = '0;
    logic        imem_en, dmem_re, dmem_we, done, err;
    logic [7:0]  imem_addr, dmem_addr;
    logic [15:0] imem_rdata = '0;
    logic [31:0] dmem_wdata, dmem_rdata = '0;

    logic [15:0] imem [32];
    logic [31:0] dmem [64];

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    zstack_core dut_i (
        .clk(clk), .rst(rst), .start(start), .sp_base(sp_base),
        .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .done(done), .err(err)
    );

    always @(posedge clk) begin
        if (imem_en) imem_rdata <= imem[imem_addr[4:0]];
        if (dmem_re) dmem_rdata <= dmem[dmem_addr[5:0]];
        if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
    end

    localparam logic [7:0] HALT = 8'h00, PUSH = 8'h01, STORE = 8'h02, POP = 8'h03,
                           ADD = 8'h10, SUB = 8'h11, MUL = 8'h12;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    function automatic logic [15:0] enc(input logic [7:0] op, input int disp);
        return {op, 8'(disp)};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) imem[i] = enc(HALT, 0);
        for (int i = 0; i < 64; i++) dmem[i] = SENT;
    endtask

    task automatic run(input logic [7:0] base);
        int t;
        @(negedge clk);
        sp_base = base;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        t = 0;
        while (!done && !err && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (t >= 400) chk("R9", "run timeout", 0, 1);
    endtask

    task automatic t_reset();
        chk("R11", "done", {31'b0, done}, 0);
        chk("R11", "err", {31'b0, err}, 0);
        chk("R11", "imem_en", {31'b0, imem_en}, 0);
        chk("R11", "mem access", {30'b0, dmem_re, dmem_we}, 0);
    endtask

    task automatic t_expression();
        clear_mem();
        dmem[8] = 7; dmem[9] = 6; dmem[10] = 5; dmem[11] = 3;
        imem[0] = enc(PUSH, 8);  imem[1] = enc(PUSH, 12); imem[2] = enc(MUL, 0);
        imem[3] = enc(PUSH, 0);  imem[4] = enc(PUSH, 4);  imem[5] = enc(MUL, 0);
        imem[6] = enc(SUB, 0);   imem[7] = enc(STORE, 16); imem[8] = enc(POP, 0);
        imem[9] = enc(HALT, 0);
        run(8'd8);
        // R5 R6: (off8*off12) - (off0*off4) = 15 - 42
        chk("R6", "expression result", dmem[12], 32'(5*3 - 7*6));
        chk("R9", "done after halt", {31'b0, done}, 1);
        chk("R7", "no fault", {31'b0, err}, 0);
    endtask

    task automatic t_sub_add_mul();
        clear_mem();
        dmem[0] = 3; dmem[1] = 10; dmem[2] = 32'h0001_0000; dmem[3] = 32'h0001_0003;
        imem[0] = enc(PUSH, 0);  imem[1] = enc(PUSH, 4); imem[2] = enc(SUB, 0);
        imem[3] = enc(STORE, 16);
        imem[4] = enc(PUSH, 8);  imem[5] = enc(PUSH, 12); imem[6] = enc(MUL, 0);
        imem[7] = enc(STORE, 20);
        imem[8] = enc(ADD, 0);   imem[9] = enc(STORE, 24); imem[10] = enc(HALT, 0);
        run(8'd0);
        chk("R6", "below minus top", dmem[4], 32'hFFFF_FFF9);
        chk("R5", "mul low word", dmem[5], 32'h0003_0000);
        chk("R5", "add", dmem[6], 32'hFFFF_FFF9 + 32'h0003_0000);
    endtask

    task automatic t_neg_disp();
        clear_mem();
        dmem[19] = 32'h55;
        imem[0] = enc(PUSH, -4); imem[1] = enc(STORE, 8); imem[2] = enc(HALT, 0);
        run(8'd20);
        chk("R2", "negative displacement push", dmem[22], 32'h55);
        chk("R3", "store address", dmem[20], SENT);
    endtask

    task automatic t_pop();
        clear_mem();
        dmem[0] = 11; dmem[1] = 22;
        imem[0] = enc(PUSH, 0); imem[1] = enc(PUSH, 4); imem[2] = enc(POP, 0);
        imem[3] = enc(STORE, 8); imem[4] = enc(STORE, 12); imem[5] = enc(HALT, 0);
        run(8'd0);
        chk("R4", "pop exposes lower entry", dmem[2], 11);
        chk("R3", "store keeps stack", dmem[3], 11);
    endtask

    task automatic t_overflow();
        clear_mem();
        dmem[0] = 1;
        for (int i = 0; i < 9; i++) imem[i] = enc(PUSH, 0);
        imem[9] = enc(STORE, 4);
        run(8'd0);
        chk("R7", "overflow err", {31'b0, err}, 1);
        chk("R7", "overflow no done", {31'b0, done}, 0);
        chk("R7", "no store after overflow", dmem[1], SENT);
    endtask

    task automatic t_underflow();
        clear_mem();
        imem[0] = enc(STORE, 4);
        run(8'd0);
        chk("R7", "store on empty err", {31'b0, err}, 1);
        chk("R7", "store on empty no write", dmem[1], SENT);
        clear_mem();
        dmem[0] = 9;
        imem[0] = enc(PUSH, 0); imem[1] = enc(ADD, 0); imem[2] = enc(STORE, 4);
        run(8'd0);
        chk("R7", "add with one entry err", {31'b0, err}, 1);
        chk("R7", "add underflow no write", dmem[1], SENT);
        clear_mem();
        imem[0] = enc(POP, 0);
        run(8'd0);
        chk("R7", "pop on empty err", {31'b0, err}, 1);
    endtask

    task automatic t_encoding_faults();
        clear_mem();
        dmem[0] = 4;
        imem[0] = enc(PUSH, 0); imem[1] = enc(STORE, 6);
        run(8'd0);
        chk("R8", "misaligned store err", {31'b0, err}, 1);
        chk("R8", "misaligned store no write", dmem[1], SENT);
        clear_mem();
        imem[0] = enc(8'h7F, 0); imem[1] = enc(PUSH, 0); imem[2] = enc(STORE, 4);
        run(8'd0);
        chk("R8", "unknown opcode err", {31'b0, err}, 1);
        chk("R8", "unknown opcode stops", dmem[1], SENT);
    endtask

    task automatic t_halt_restart();
        int fetches;
        clear_mem();
        dmem[0] = 77;
        imem[0] = enc(PUSH, 0); imem[1] = enc(HALT, 0); imem[2] = enc(STORE, 4);
        run(8'd0);   // previous run left err high; R1 start clears it
        chk("R1", "restart clears err", {31'b0, err}, 0);
        chk("R9", "halt done", {31'b0, done}, 1);
        fetches = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (imem_en) fetches++;
        end
        chk("R9", "no fetch after halt", 32'(fetches), 0);
        chk("R9", "done holds", {31'b0, done}, 1);
        chk("R9", "instruction after halt ignored", dmem[1], SENT);
        // R1: restart from halted state, stack emptied: store first must fault
        imem[0] = enc(STORE, 4);
        run(8'd0);
        chk("R1", "stack cleared on start", {31'b0, err}, 1);
        chk("R1", "start clears done", {31'b0, done}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_expression();
        t_sub_add_mul();
        t_neg_disp();
        t_pop();
        t_overflow();
        t_underflow();
        t_encoding_faults();
        t_halt_restart();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule